// File: doc/BRIEF.md
# Dual-Channel Crossing Frame Decoder

The decoder accepts one 16-bit frame per bunch crossing. Each frame carries two 7-bit floating-point channel codes and one 2-bit capacitor index that the front end shares between the two channels. The block splits the frame and expands each code into a 16-bit linear energy through a combinational table. It adds two flags to each channel: a capacitor-sequence error bit and a link error bit. The link error bit is a copy of a per-frame error flag that comes from the receiver ahead of the block.

The capacitor index should step forward by one, modulo four, on every accepted frame. The block counts each break in that sequence in a saturating counter and also holds a sticky flag. It does not report these at once. It reports them on frames that the upstream logic marks as orbit-gap crossings. On those frames both channel slots carry the count and the flag in place of energy, and the counter and the flag are then cleared. One registered output stream carries the decoded result, and the trigger path and the readout path both read it at the same time.

Both edges of the block are valid/ready streams. The output is one register deep. A frame is accepted when `in_valid` and `in_ready` are both high. `in_ready` is high when the output register is empty or is being drained in the same cycle. Once `out_valid` is high, the output payload stays unchanged until `out_ready` is seen high. A stalled output therefore blocks the input, and no frame is dropped.

Top module: `dcf_frame_decoder`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it is released, `out_valid` is 0 and `in_ready` is 1.
- R2: Frame bits [6:0] hold the channel A code, bits [13:7] hold the channel B code, and bits [15:14] hold the capacitor index. Within each code, bits [6:5] are the exponent and bits [4:0] are the mantissa.
- R3: On a non-gap frame, each channel energy equals ((mantissa + 1) << (3 × exponent)) − 1. The largest value, 16383, comes from code 127.
- R4: An accepted frame appears on the output on the next cycle with `out_valid` high. `in_ready` equals (not `out_valid`) or `out_ready`. While `out_valid` is high and `out_ready` is low, every output holds its value.
- R5: Both frame-error outputs equal the `in_link_err` value that came with the accepted frame. This applies to gap frames and to data frames alike.
- R6: The first frame accepted after reset is never a mismatch. Every later accepted frame is a mismatch when its capacitor index differs from (previous accepted index + 1) mod 4. On a non-gap frame, both cap-error outputs show whether that frame was a mismatch.
- R7: Each mismatch on a non-gap frame adds one to an 8-bit count that stops at 255, and it sets a sticky flag. Stalled cycles do not change either of them.
- R8: On an accepted frame with `in_gap` high, `out_gap` is 1. Both energy outputs equal {7'b0, flag, count[7:0]} with the values held before the frame, and both cap-error outputs equal the flag. After that frame, the count and the flag hold only this frame's own mismatch (0 or 1).
- R9: A gap frame's capacitor index still becomes the reference that the next frame is checked against.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input frame valid |
| in_ready | output | 1 | Block can take a frame |
| in_frame | input | 16 | Two channel codes and the capacitor index |
| in_link_err | input | 1 | Receiver error tag for this frame |
| in_gap | input | 1 | Frame falls in the orbit gap |
| out_valid | output | 1 | Output payload valid |
| out_ready | input | 1 | Both downstream paths take the payload |
| out_gap | output | 1 | Payload is an error report, not energy |
| ch_a_energy | output | 16 | Channel A linear energy or error report |
| ch_a_cap_err | output | 1 | Channel A capacitor sequence error |
| ch_a_frame_err | output | 1 | Channel A link error |
| ch_b_energy | output | 16 | Channel B linear energy or error report |
| ch_b_cap_err | output | 1 | Channel B capacitor sequence error |
| ch_b_frame_err | output | 1 | Channel B link error |

## Verification
A wrong table entry or a wrong field split shows up on the very next output beat as a wrong energy, so every one of the 128 codes is driven through both channels. A wrong capacitor reference or a missed first-frame exemption shows up at once as a wrong cap-error bit. A wrong count, a failed saturation or a missed clear stays hidden until the next gap frame, so gap frames follow every error-injection phase, and one of them comes after more than 255 mismatches. A broken stall rule shows up as a changed payload or a wrong `in_ready` on the stalled cycle itself, so the output is stalled at random.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  localparam int unsigned DCF_EXP_W    = 2;
  localparam int unsigned DCF_MAN_W    = 5;
  localparam int unsigned DCF_CAP_W    = 2;
  localparam int unsigned DCF_ENERGY_W = 16;
  localparam int unsigned DCF_CNT_W    = 8;
  localparam int unsigned DCF_STEP     = 3;
endpackage

// File: rtl/dcf_lin_lut.sv
module dcf_lin_lut #(
  parameter int unsigned EXP_W    = dcf_pkg::DCF_EXP_W,
  parameter int unsigned MAN_W    = dcf_pkg::DCF_MAN_W,
  parameter int unsigned ENERGY_W = dcf_pkg::DCF_ENERGY_W,
  parameter int unsigned STEP     = dcf_pkg::DCF_STEP
) (
  input  logic [EXP_W+MAN_W-1:0] code_i,
  output logic [ENERGY_W-1:0]    energy_o
);
  localparam int unsigned CODE_W = EXP_W + MAN_W;
  localparam int unsigned DEPTH  = 1 << CODE_W;

  function automatic logic [ENERGY_W-1:0] lin_entry(input int unsigned idx);
    int unsigned ex;
    int unsigned mn;
    ex = idx >> MAN_W;
    mn = idx & ((1 << MAN_W) - 1);
    return ENERGY_W'(((mn + 1) << (STEP * ex)) - 1);
  endfunction

  logic [ENERGY_W-1:0] table_w [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    assign table_w[g] = lin_entry(g);
  end

  assign energy_o = table_w[code_i];
endmodule

// File: rtl/dcf_cap_track.sv
module dcf_cap_track #(
  parameter int unsigned CAP_W = dcf_pkg::DCF_CAP_W,
  parameter int unsigned CNT_W = dcf_pkg::DCF_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire_i,
  input  logic             gap_i,
  input  logic [CAP_W-1:0] cap_i,
  output logic             mismatch_o,
  output logic [CNT_W-1:0] count_o,
  output logic             flag_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             have_q;
  logic [CAP_W-1:0] prev_q;
  logic [CAP_W-1:0] expect_w;

  assign expect_w   = prev_q + CAP_W'(1);
  assign mismatch_o = fire_i && have_q && (cap_i != expect_w);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_q  <= 1'b0;
      prev_q  <= '0;
      count_o <= '0;
      flag_o  <= 1'b0;
    end else if (fire_i) begin
      have_q <= 1'b1;
      prev_q <= cap_i;
      if (gap_i) begin
        count_o <= CNT_W'(mismatch_o);
        flag_o  <= mismatch_o;
      end else begin
        if (mismatch_o && count_o != CNT_MAX) count_o <= count_o + CNT_W'(1);
        flag_o <= flag_o | mismatch_o;
      end
    end
  end
endmodule

// File: rtl/dcf_out_reg.sv
module dcf_out_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         ready_i,
  input  logic [W-1:0] d_i,
  output logic         valid_o,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      q_o     <= '0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      q_o     <= d_i;
    end else if (ready_i) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/dcf_frame_decoder.sv
module dcf_frame_decoder #(
  parameter int unsigned EXP_W    = dcf_pkg::DCF_EXP_W,
  parameter int unsigned MAN_W    = dcf_pkg::DCF_MAN_W,
  parameter int unsigned CAP_W    = dcf_pkg::DCF_CAP_W,
  parameter int unsigned ENERGY_W = dcf_pkg::DCF_ENERGY_W,
  parameter int unsigned CNT_W    = dcf_pkg::DCF_CNT_W,
  parameter int unsigned STEP     = dcf_pkg::DCF_STEP
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 in_valid,
  output logic                                 in_ready,
  input  logic [2*(EXP_W+MAN_W)+CAP_W-1:0]     in_frame,
  input  logic                                 in_link_err,
  input  logic                                 in_gap,
  output logic                                 out_valid,
  input  logic                                 out_ready,
  output logic                                 out_gap,
  output logic [ENERGY_W-1:0]                  ch_a_energy,
  output logic                                 ch_a_cap_err,
  output logic                                 ch_a_frame_err,
  output logic [ENERGY_W-1:0]                  ch_b_energy,
  output logic                                 ch_b_cap_err,
  output logic                                 ch_b_frame_err
);
  localparam int unsigned CODE_W  = EXP_W + MAN_W;
  localparam int unsigned FRAME_W = 2 * CODE_W + CAP_W;
  localparam int unsigned CH_W    = ENERGY_W + 2;
  localparam int unsigned PAY_W   = 1 + 2 * CH_W;

  if (ENERGY_W < CNT_W + 1) begin : g_width_bad
    initial $error("energy field too narrow for the gap report");
  end

  logic                fire;
  logic [CODE_W-1:0]   code  [2];
  logic [ENERGY_W-1:0] lin   [2];
  logic [CH_W-1:0]     chan_d[2];
  logic [CAP_W-1:0]    cap;
  logic                mismatch;
  logic [CNT_W-1:0]    cnt_q;
  logic                flag_q;
  logic [ENERGY_W-1:0] gap_word;
  logic [PAY_W-1:0]    pay_d;
  logic [PAY_W-1:0]    pay_q;

  assign fire     = in_valid && in_ready;
  assign in_ready = !out_valid || out_ready;
  assign code[0]  = in_frame[CODE_W-1:0];
  assign code[1]  = in_frame[2*CODE_W-1:CODE_W];
  assign cap      = in_frame[FRAME_W-1:2*CODE_W];
  assign gap_word = ENERGY_W'({flag_q, cnt_q});

  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    dcf_lin_lut #(
      .EXP_W(EXP_W), .MAN_W(MAN_W), .ENERGY_W(ENERGY_W), .STEP(STEP)
    ) u_lut (
      .code_i  (code[ch]),
      .energy_o(lin[ch])
    );

    always_comb begin
      if (in_gap) chan_d[ch] = {gap_word, flag_q, in_link_err};
      else        chan_d[ch] = {lin[ch], mismatch, in_link_err};
    end
  end

  dcf_cap_track #(.CAP_W(CAP_W), .CNT_W(CNT_W)) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire_i    (fire),
    .gap_i     (in_gap),
    .cap_i     (cap),
    .mismatch_o(mismatch),
    .count_o   (cnt_q),
    .flag_o    (flag_q)
  );

  assign pay_d = {in_gap, chan_d[1], chan_d[0]};

  dcf_out_reg #(.W(PAY_W)) u_out (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (fire),
    .ready_i(out_ready),
    .d_i    (pay_d),
    .valid_o(out_valid),
    .q_o    (pay_q)
  );

  assign out_gap        = pay_q[PAY_W-1];
  assign ch_b_energy    = pay_q[2*CH_W-1 -: ENERGY_W];
  assign ch_b_cap_err   = pay_q[CH_W+1];
  assign ch_b_frame_err = pay_q[CH_W];
  assign ch_a_energy    = pay_q[CH_W-1 -: ENERGY_W];
  assign ch_a_cap_err   = pay_q[1];
  assign ch_a_frame_err = pay_q[0];
endmodule

// File: rtl/dcf_frame_decoder_chk.sv
module dcf_frame_decoder_chk #(
  parameter int unsigned ENERGY_W = 16,
  parameter int unsigned CNT_W    = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic                in_ready,
  input logic                in_link_err,
  input logic                out_valid,
  input logic                out_ready,
  input logic                out_gap,
  input logic [ENERGY_W-1:0] ch_a_energy,
  input logic                ch_a_cap_err,
  input logic                ch_a_frame_err,
  input logic [ENERGY_W-1:0] ch_b_energy,
  input logic                ch_b_cap_err,
  input logic                ch_b_frame_err
);
  // R4
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable({out_gap, ch_a_energy, ch_a_cap_err,
      ch_a_frame_err, ch_b_energy, ch_b_cap_err, ch_b_frame_err}));

  // R4
  accept_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R1
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready));

  // R5
  frame_err_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> ch_a_frame_err == $past(in_link_err) &&
                             ch_b_frame_err == $past(in_link_err));

  // R8
  gap_layout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_gap |-> ch_a_energy[ENERGY_W-1:CNT_W+1] == '0 &&
      ch_a_energy == ch_b_energy && ch_a_cap_err == ch_a_energy[CNT_W]);

  // R6
  cap_err_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ch_a_cap_err == ch_b_cap_err);
endmodule

bind dcf_frame_decoder dcf_frame_decoder_chk #(
  .ENERGY_W(ENERGY_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_link_err(in_link_err), .out_valid(out_valid), .out_ready(out_ready),
  .out_gap(out_gap), .ch_a_energy(ch_a_energy), .ch_a_cap_err(ch_a_cap_err),
  .ch_a_frame_err(ch_a_frame_err), .ch_b_energy(ch_b_energy),
  .ch_b_cap_err(ch_b_cap_err), .ch_b_frame_err(ch_b_frame_err)
);

// File: tb/dcf_frame_decoder_bench.sv
module dcf_frame_decoder_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_frame = '0;
  logic        in_link_err = 1'b0;
  logic        in_gap = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic        out_gap;
  logic [15:0] ch_a_energy, ch_b_energy;
  logic        ch_a_cap_err, ch_a_frame_err, ch_b_cap_err, ch_b_frame_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  dcf_frame_decoder u_dcf_frame_decoder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_frame(in_frame), .in_link_err(in_link_err), .in_gap(in_gap),
    .out_valid(out_valid), .out_ready(out_ready), .out_gap(out_gap),
    .ch_a_energy(ch_a_energy), .ch_a_cap_err(ch_a_cap_err),
    .ch_a_frame_err(ch_a_frame_err), .ch_b_energy(ch_b_energy),
    .ch_b_cap_err(ch_b_cap_err), .ch_b_frame_err(ch_b_frame_err)
  );

  typedef struct {
    bit gap; int ea; int eb; bit ca; bit cb; bit fa; bit fb;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  bit   done = 0;
  bit   ref_have = 0;
  int   ref_prev = 0;
  int   ref_cnt = 0;
  bit   ref_flag = 0;
  int   capc = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic int lin(input int code);
    int e, m;
    e = code >> 5;
    m = code & 31;
    return ((m + 1) << (3 * e)) - 1;
  endfunction

  function automatic logic [15:0] mk(input int a, input int b, input int c);
    return {c[1:0], b[6:0], a[6:0]};
  endfunction

  // One cycle: compare outputs against the model, drive, update the model.
  task automatic step(input bit v, input logic [15:0] f, input bit le, input bit g,
                      input bit r, output bit fired);
    bit fout;
    exp_t e;
    @(negedge clk);
    chk(out_valid == (q.size() > 0), "R4 out_valid", int'(out_valid), q.size());
    if (q.size() > 0 && out_valid) begin
      e = q[0];
      chk(out_gap == e.gap, "R8 out_gap", int'(out_gap), int'(e.gap));
      chk(ch_a_energy == e.ea[15:0], e.gap ? "R8 ch_a report" : "R3 ch_a energy",
          int'(ch_a_energy), e.ea);
      chk(ch_b_energy == e.eb[15:0], e.gap ? "R8 ch_b report" : "R3 ch_b energy",
          int'(ch_b_energy), e.eb);
      chk(ch_a_cap_err == e.ca, e.gap ? "R8 ch_a flag" : "R6 ch_a cap_err",
          int'(ch_a_cap_err), int'(e.ca));
      chk(ch_b_cap_err == e.cb, e.gap ? "R8 ch_b flag" : "R6 ch_b cap_err",
          int'(ch_b_cap_err), int'(e.cb));
      chk(ch_a_frame_err == e.fa && ch_b_frame_err == e.fb, "R5 frame_err",
          int'({ch_a_frame_err, ch_b_frame_err}), int'({e.fa, e.fb}));
    end
    in_valid = v; in_frame = f; in_link_err = le; in_gap = g; out_ready = r;
    #1;
    chk(in_ready == (q.size() == 0 || r), "R4 in_ready", int'(in_ready),
        int'(q.size() == 0 || r));
    fired = v && in_ready;
    fout  = out_valid && r;
    if (fout && q.size() > 0) void'(q.pop_front());
    if (fired) begin
      int a, b, c;
      bit mm;
      a = int'(f[6:0]); b = int'(f[13:7]); c = int'(f[15:14]);
      mm = ref_have && (c != ((ref_prev + 1) % 4));
      e.gap = g; e.fa = le; e.fb = le;
      if (g) begin
        e.ea = (int'(ref_flag) << 8) | ref_cnt; e.eb = e.ea;
        e.ca = ref_flag; e.cb = ref_flag;
        ref_cnt = int'(mm); ref_flag = mm;
      end else begin
        e.ea = lin(a); e.eb = lin(b); e.ca = mm; e.cb = mm;
        if (mm && ref_cnt < 255) ref_cnt++;
        ref_flag = ref_flag | mm;
      end
      ref_prev = c; ref_have = 1;
      q.push_back(e);
    end
  endtask

  // Offer a frame until it is accepted; the capacitor counter advances on accept.
  task automatic send(input int a, input int b, input int c, input bit le,
                      input bit g, input bit rnd_ready);
    bit fired;
    fired = 0;
    while (!fired) begin
      step(1'b1, mk(a, b, c), le, g, rnd_ready ? bit'($urandom % 3 != 0) : 1'b1, fired);
    end
  endtask

  task automatic idle(input int n);
    bit fired;
    for (int i = 0; i < n; i++) step(1'b0, '0, 1'b0, 1'b0, 1'b1, fired);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    // R1: held in reset
    chk(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R1 in_ready in reset", int'(in_ready), 1);
    q.delete();
    ref_have = 0; ref_prev = 0; ref_cnt = 0; ref_flag = 0;
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1: first cycle after release
    idle(1);
    // R2 R3: every code on both channels, proper rotation from an arbitrary start
    capc = 2;
    for (int i = 0; i < 128; i++) begin
      send(i, 127 - i, capc, 1'b0, 1'b0, 1'b0);
      capc = (capc + 1) % 4;
    end
    // R8: gap after a clean run reports zero
    send(5, 6, capc, 1'b0, 1'b1, 1'b0); capc = (capc + 1) % 4;
    // R4: random stalls with correct rotation, R5 link errors
    for (int i = 0; i < 150; i++) begin
      send(int'($urandom % 128), int'($urandom % 128), capc, bit'($urandom % 4 == 0),
           1'b0, 1'b1);
      capc = (capc + 1) % 4;
      if ($urandom % 4 == 0) idle(1);
    end
    // R6 R7: injected mismatches
    for (int i = 0; i < 40; i++) begin
      if (i % 7 == 3) capc = (capc + 2) % 4;
      send(int'($urandom % 128), 100, capc, 1'b0, 1'b0, 1'b1);
      capc = (capc + 1) % 4;
    end
    // R8: report, then a mismatching gap frame, then a clean gap frame
    send(1, 2, capc, 1'b1, 1'b1, 1'b0); capc = (capc + 1) % 4;
    send(1, 2, (capc + 1) % 4, 1'b0, 1'b1, 1'b0); capc = (capc + 2) % 4;
    send(1, 2, capc, 1'b0, 1'b1, 1'b0); capc = (capc + 1) % 4;
    // R9: reference follows the gap frame index
    send(9, 9, capc, 1'b0, 1'b0, 1'b0); capc = (capc + 1) % 4;
    send(3, 3, capc, 1'b0, 1'b1, 1'b0); capc = (capc + 1) % 4;
    // R7: saturation beyond 255 mismatches, with stalls
    for (int i = 0; i < 300; i++) send(127, 0, 0, 1'b0, 1'b0, 1'b1);
    send(0, 127, 1, 1'b0, 1'b1, 1'b0);
    send(0, 0, 2, 1'b0, 1'b1, 1'b0);
    // R6: first frame after reset is exempt
    do_reset();
    idle(1);
    send(20, 21, 3, 1'b0, 1'b0, 1'b0);
    send(22, 23, 0, 1'b0, 1'b0, 1'b0);
    send(0, 0, 1, 1'b0, 1'b1, 1'b0);
    idle(4);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule